// File: doc/BRIEF.md
# Phase Capture Register with Interrupt

This block times an incoming measurement edge against a reference period and gives the result in thousandths of a cycle. A free-running phase counter runs from 0 to 999 once per reference period. It is stepped by an internal step enable that fires once every `STEP_DIV` clocks. Each measurement edge copies the counter into a 12-bit result register and raises an interrupt request.

A processor reads the result through a byte-wide port as two bytes, low byte first. Reading the low byte saves the upper nibble into a shadow register, so the later high-byte read returns the same capture even if a new one has landed in between. While the request is pending the block presents priority level 5. When the processor acknowledges, the block drives its own vector byte; it does not rely on an autovector.

The measurement edge is a plain single-cycle pulse, synchronous to `clk`, and is never stalled. A capture is always accepted. If a result is overwritten before the software has read it, a sticky overrun flag records the loss. The read port is a plain strobe: a read completes in the cycle it is asserted and has no back-pressure.

Top module: `phase_capture_irq`

## Requirements
- R1: The phase counter starts at 0 after reset and advances by one on every step enable, one enable every `STEP_DIV` clocks (default 2). It counts 0 to 999 and wraps from 999 to 0, so a capture in the edge following clock edge e after reset holds floor(e/STEP_DIV) mod 1000.
- R2: A clock edge with `meas_edge` high loads the counter value from before that edge into the 12-bit result. A low-byte read (`rd_en`=1, `rd_hi`=0) returns result bits 7:0 on `rd_data` in the same cycle.
- R3: A high-byte read (`rd_en`=1, `rd_hi`=1) returns, in `rd_data` bits 3:0, result bits 11:8 as they stood at the most recent low-byte read. Bits 7:4 are zero. Captures after that low read do not change it.
- R4: A capture sets the interrupt request. While it is pending, `irq_ipl` is 3'b101; otherwise `irq_ipl` is 3'b000.
- R5: The request clears at the edge after an acknowledge (`iack`=1) or after a low-byte read, whichever comes first. A capture in the same cycle keeps it set.
- R6: While `iack` is high and a request is pending, `irq_vec` carries the vector parameter (default 8'h55; legal values 8'h55, 8'hAA, 8'hFF). At all other times it is 8'h00.
- R7: A capture that arrives while the previous result has not been low-read sets the sticky `overrun` flag. A low-byte read with no capture in the same cycle clears it.
- R8: After reset the request, `irq_ipl`, `overrun`, the result and the shadow nibble are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_edge | input | 1 | Single-cycle measurement edge pulse |
| rd_en | input | 1 | Read strobe |
| rd_hi | input | 1 | Byte select: 0 low byte, 1 high byte |
| rd_data | output | 8 | Read data, valid in the strobe cycle, 0 otherwise |
| iack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Pending interrupt request |
| irq_ipl | output | 3 | Priority level lines |
| irq_vec | output | 8 | Vector byte during acknowledge |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The hardest case to reach is a capture that lands between the low and high reads of one pair, in the same cycle as an acknowledge or a low read. That case is where tearing, a lost clear or a wrong overrun would show. Random stimulus sets read, acknowledge and capture strobes on independent random bits, so these collisions occur often over several thousand cycles. The run covers more than two full wraps of the counter. Directed sequences force a torn-pair attempt and a capture during acknowledge.

// File: rtl/phase_pkg.sv
package phase_pkg;
  localparam int unsigned PHASE_MOD  = 1000;
  localparam int unsigned RESULT_W   = 12;
  localparam logic [2:0]  PHASE_IPL  = 3'b101;
  localparam logic [7:0]  VEC_IDLE   = 8'h00;
endpackage

// File: rtl/phase_step_gen.sv
module phase_step_gen #(
  parameter int unsigned STEP_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  generate
    if (STEP_DIV <= 1) begin : g_every
      assign step = 1'b1;
    end else begin : g_div
      localparam int unsigned DW = $clog2(STEP_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          div_q <= '0;
        else if (div_q == DW'(STEP_DIV - 1)) div_q <= '0;
        else                                 div_q <= div_q + 1'b1;
      end
      assign step = (div_q == DW'(STEP_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/phase_cnt.sv
module phase_cnt #(
  parameter int unsigned MOD = 1000,
  localparam int unsigned CW = $clog2(MOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           count <= '0;
    else if (step && count == CW'(MOD-1)) count <= '0;
    else if (step)                        count <= count + 1'b1;
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == CW'(MOD-1)) |=> (count == '0)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= CW'(MOD-1))); // R1
endmodule

// File: rtl/phase_result.sv
module phase_result #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned CW    = 10,
  localparam int unsigned HW   = RES_W - 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CW-1:0]    count,
  input  logic             rd_lo,
  output logic [RES_W-1:0] result,
  output logic [HW-1:0]    shadow,
  output logic             ovr
);
  logic fresh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      shadow <= '0;
      fresh  <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (cap)   result <= RES_W'(count);
      if (rd_lo) shadow <= result[RES_W-1:8];
      fresh <= cap | (fresh & ~rd_lo);
      ovr   <= (cap & fresh & ~rd_lo) | (ovr & ~rd_lo);
    end
  end

  AST_CAPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (result == RES_W'($past(count)))); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow)); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && fresh && !rd_lo) |=> ovr); // R7
endmodule

// File: rtl/phase_irq.sv
module phase_irq
  import phase_pkg::*;
#(
  parameter logic [7:0] VECTOR = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic       rd_lo,
  input  logic       iack,
  output logic       irq,
  output logic [2:0] ipl,
  output logic [7:0] vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= cap | (irq & ~rd_lo & ~iack);
  end

  assign ipl = irq ? PHASE_IPL : 3'b000;
  assign vec = (irq && iack) ? VECTOR : VEC_IDLE;

  initial begin
    AST_VEC_LEGAL: assert (VECTOR == 8'h55 || VECTOR == 8'hAA || VECTOR == 8'hFF); // R6
  end
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> irq); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((iack || rd_lo) && !cap) |=> !irq); // R5
endmodule

// File: rtl/phase_capture_irq.sv
module phase_capture_irq
  import phase_pkg::*;
#(
  parameter int unsigned STEP_DIV = 2,
  parameter logic [7:0]  VECTOR   = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_edge,
  input  logic       rd_en,
  input  logic       rd_hi,
  output logic [7:0] rd_data,
  input  logic       iack,
  output logic       irq_req,
  output logic [2:0] irq_ipl,
  output logic [7:0] irq_vec,
  output logic       overrun
);
  localparam int unsigned CW = $clog2(PHASE_MOD);
  localparam int unsigned HW = RESULT_W - 8;

  logic                step;
  logic [CW-1:0]       count;
  logic [RESULT_W-1:0] result;
  logic [HW-1:0]       shadow;
  logic                rd_lo;

  assign rd_lo = rd_en & ~rd_hi;

  phase_step_gen #(.STEP_DIV(STEP_DIV)) u_step (
    .clk(clk), .rst_n(rst_n), .step(step));

  phase_cnt #(.MOD(PHASE_MOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .count(count));

  phase_result #(.RES_W(RESULT_W), .CW(CW)) u_res (
    .clk(clk), .rst_n(rst_n), .cap(meas_edge), .count(count),
    .rd_lo(rd_lo), .result(result), .shadow(shadow), .ovr(overrun));

  phase_irq #(.VECTOR(VECTOR)) u_irq (
    .clk(clk), .rst_n(rst_n), .cap(meas_edge), .rd_lo(rd_lo),
    .iack(iack), .irq(irq_req), .ipl(irq_ipl), .vec(irq_vec));

  always_comb begin
    if (!rd_en)     rd_data = 8'h00;
    else if (rd_hi) rd_data = {{(8-HW){1'b0}}, shadow};
    else            rd_data = result[7:0];
  end

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hi) |-> (rd_data[7:HW] == '0)); // R3
endmodule

// File: tb/tb_phase_capture_irq.sv
module tb_phase_capture_irq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2;
  localparam int MOD = 1000;
  localparam logic [7:0] VEC = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas_edge = 1'b0, rd_en = 1'b0, rd_hi = 1'b0, iack = 1'b0;
  logic [7:0] rd_data, irq_vec;
  logic [2:0] irq_ipl;
  logic irq_req, overrun;

  phase_capture_irq #(.STEP_DIV(DIV), .VECTOR(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .meas_edge(meas_edge), .rd_en(rd_en),
    .rd_hi(rd_hi), .rd_data(rd_data), .iack(iack), .irq_req(irq_req),
    .irq_ipl(irq_ipl), .irq_vec(irq_vec), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int m_res = 0, m_sh = 0;
  bit m_fresh = 0, m_ovr = 0, m_pend = 0;

  function automatic int exp_phase(int edges);
    return (edges / DIV) % MOD;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic op(bit me, bit re, bit rh, bit ack);
    bit lo;
    @(negedge clk);
    meas_edge = me; rd_en = re; rd_hi = rh; iack = ack;
    #1;
    chk("R4 irq", int'(irq_req), int'(m_pend));
    chk("R4 ipl", int'(irq_ipl), m_pend ? 5 : 0);
    chk("R7 ovr", int'(overrun), int'(m_ovr));
    chk("R6 vec", int'(irq_vec), (ack && m_pend) ? int'(VEC) : 0);
    if (re && !rh) chk("R2 lo", int'(rd_data), m_res & 8'hFF);
    if (re && rh)  chk("R3 hi", int'(rd_data), m_sh);
    lo = re && !rh;
    if (lo) m_sh = (m_res >> 8) & 4'hF;
    m_ovr  = (me && m_fresh && !lo) || (m_ovr && !lo);
    m_pend = me || (m_pend && !lo && !ack);
    m_fresh = me || (m_fresh && !lo);
    if (me) m_res = exp_phase(cyc);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3);
    // R8 reset state
    chk("R8 irq", int'(irq_req), 0);
    chk("R8 ipl", int'(irq_ipl), 0);
    chk("R8 ovr", int'(overrun), 0);
    @(negedge clk); rst_n = 1'b1;
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    // R2 R1 first capture after a few steps
    repeat (7) op(0, 0, 0, 0);
    op(1, 0, 0, 0);
    op(0, 0, 0, 1);   // R5 ack clears, R6 vector
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    // R3 tearing attempt: low read, capture, high read returns frozen nibble
    repeat (600) op(0, 0, 0, 0);
    op(1, 0, 0, 0);
    op(0, 1, 0, 0);
    repeat (500) op(0, 0, 0, 0);
    op(1, 0, 0, 0);
    op(0, 1, 1, 0);
    // R7 overrun, then cleared by low read
    op(1, 0, 0, 0);
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    // R5 capture same cycle as ack keeps request
    op(1, 0, 0, 1);
    op(0, 0, 0, 0);
    op(0, 1, 0, 0);
    // R1 wrap across 999 -> 0 and random mix
    for (int i = 0; i < 6000; i++) begin
      bit me, re, rh, ak;
      me = ($urandom % 8) == 0;
      re = ($urandom % 4) == 0;
      rh = $urandom % 2;
      ak = ($urandom % 6) == 0;
      op(me, re, rh, ak);
    end
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule